// File: doc/BRIEF.md
# Issue-Time Load-Store Queue Bank

This block is one slice of a memory-disambiguation queue. A load or store claims a slot only at the moment it issues, and it may land in any slot that happens to be free. Slot position therefore says nothing about program order. Every entry carries an explicit age tag, and all ordering decisions are rebuilt from those tags with a wrap-aware comparison.

Each issued request searches the bank associatively against the entries already present, using the contents as they stood before that request. A load searches for the youngest older store that touches the same word with an overlapping byte mask, and takes that store's data. A store searches for younger loads that already read an overlapping location. It reports an ordering violation, together with the age of the oldest such load, so that the pipeline can restart from there. The result is registered and appears one cycle after the request. If a request arrives when no slot is free, the bank raises overflow so that the pipeline can flush and replay. Entries leave the bank on commit, which matches one age tag, and on flush, which removes everything younger than a given tag. In a banked system the low word-address bits choose the bank, and this bank ignores any address that belongs to another bank.

Top module: `lsq_bank`

## Requirements
- R1: An accepted request (req_valid high, address in this bank, flush_valid low) takes a free slot if one exists, and produces rsp_valid high on the following cycle. No other cycle has rsp_valid high.
- R2: With BANK_BITS > 0, a request whose req_addr[BANK_BITS-1:0] differs from BANK_ID is ignored: it produces no response and takes no slot.
- R3: A load reports rsp_fwd_hit with the data of the youngest valid store that is older than the load, has the same word address, and has a byte mask that shares at least one set bit with the load's mask.
- R4: A load with no such store reports rsp_fwd_hit low and rsp_fwd_data zero. Younger stores, stores to other words and stores with disjoint masks are never forwarded.
- R5: A store reports rsp_viol when a valid load that is younger than the store, has the same word address and has an overlapping mask is present. rsp_viol_age then holds the age of the oldest such load. Otherwise rsp_viol is low and rsp_viol_age is zero.
- R6: Tag a is older than tag b exactly when (a - b) modulo 2^AGE_W has its top bit set. Equal tags are neither older nor younger.
- R7: bank_full is high exactly when every slot is valid. An accepted request that finds no free slot returns rsp_overflow high, with rsp_fwd_hit and rsp_viol low, and takes no slot.
- R8: commit_valid frees every valid entry whose tag equals commit_age. A committed store no longer forwards, and its slot becomes free.
- R9: flush_valid removes in one cycle every entry whose tag is younger than flush_age. A request presented in the same cycle is ignored.
- R10: After reset the bank is empty and every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Issue request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_age | input | AGE_W | Age tag of the request |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | MASK_W | Byte mask |
| req_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit an age tag |
| commit_age | input | AGE_W | Tag to commit |
| flush_valid | input | 1 | Flush younger entries |
| flush_age | input | AGE_W | Flush boundary tag |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_overflow | output | 1 | No free slot for that request |
| rsp_fwd_hit | output | 1 | Load found a forwarding store |
| rsp_fwd_data | output | DATA_W | Forwarded store data |
| rsp_viol | output | 1 | Store found a younger overlapping load |
| rsp_viol_age | output | AGE_W | Age of the oldest violating load |
| bank_full | output | 1 | All slots occupied |

## Verification
The bench builds the bank with 8 slots, 8-bit tags, a 16-bit word address and two interleave bits with BANK_ID 1. The small depth makes overflow and slot reuse after commit happen many times within a few hundred requests. The two interleave bits make addresses that belong to other banks easy to generate. Because the tags are 8 bits wide, the random phase, whose age window slides forward on every round, wraps the tag space several times, so the modular older-than rule is exercised across the wrap point as well as at the directed ages near 255 and 0.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;
endpackage

// File: rtl/lsq_free_enc.sv
module lsq_free_enc #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free_vec,
    output logic [IW-1:0] free_idx,
    output logic          free_any
);
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = IW'(i);
        end
        free_any = |free_vec;
    end
endmodule

// File: rtl/lsq_cam.sv
module lsq_cam #(
    parameter int N      = 32,
    parameter int AGE_W  = 8,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 4
) (
    input  logic [N-1:0]              ent_vld,
    input  logic [N-1:0]              ent_st,
    input  logic [N-1:0][AGE_W-1:0]   ent_age,
    input  logic [N-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [N-1:0][MASK_W-1:0]  ent_mask,
    input  logic                      q_st,
    input  logic [AGE_W-1:0]          q_age,
    input  logic [ADDR_W-1:0]         q_addr,
    input  logic [MASK_W-1:0]         q_mask,
    input  logic [AGE_W-1:0]          fl_age,
    output logic [N-1:0]              fwd_cand,
    output logic [N-1:0]              viol_cand,
    output logic [N-1:0]              kill_vec
);
    function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic hit;
        assign hit          = ent_vld[g] && (ent_addr[g] == q_addr) && (|(ent_mask[g] & q_mask));
        assign fwd_cand[g]  = hit && ent_st[g] && !q_st && is_older(ent_age[g], q_age);
        assign viol_cand[g] = hit && !ent_st[g] && q_st && is_older(q_age, ent_age[g]);
        assign kill_vec[g]  = ent_vld[g] && is_older(fl_age, ent_age[g]);
    end
endmodule

// File: rtl/lsq_age_pick.sv
module lsq_age_pick #(
    parameter int N        = 32,
    parameter int AGE_W    = 8,
    parameter bit YOUNGEST = 1'b1,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][AGE_W-1:0] ages,
    output logic [IW-1:0]           pick_idx,
    output logic                    found
);
    function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    logic [AGE_W-1:0] best;

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        best     = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found ||
                (YOUNGEST ? is_older(best, ages[i]) : is_older(ages[i], best)))) begin
                found    = 1'b1;
                pick_idx = IW'(i);
                best     = ages[i];
            end
        end
    end
endmodule

// File: rtl/lsq_bank.sv
module lsq_bank #(
    parameter int N         = 32,
    parameter int AGE_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MASK_W    = 4,
    parameter int BANK_BITS = 0,
    parameter int BANK_ID   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [AGE_W-1:0]  req_age,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MASK_W-1:0] req_mask,
    input  logic [DATA_W-1:0] req_data,
    input  logic              commit_valid,
    input  logic [AGE_W-1:0]  commit_age,
    input  logic              flush_valid,
    input  logic [AGE_W-1:0]  flush_age,
    output logic              rsp_valid,
    output logic              rsp_overflow,
    output logic              rsp_fwd_hit,
    output logic [DATA_W-1:0] rsp_fwd_data,
    output logic              rsp_viol,
    output logic [AGE_W-1:0]  rsp_viol_age,
    output logic              bank_full
);
    import lsq_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]              vld;
        logic [N-1:0]              st;
        logic [N-1:0][AGE_W-1:0]   age;
        logic [N-1:0][ADDR_W-1:0]  addr;
        logic [N-1:0][MASK_W-1:0]  mask;
        logic [N-1:0][DATA_W-1:0]  data;
        logic                      rsp_vld;
        logic                      rsp_ovf;
        logic                      rsp_hit;
        logic [DATA_W-1:0]         rsp_data;
        logic                      rsp_viol;
        logic [AGE_W-1:0]          rsp_vage;
    } state_t;

    state_t state_d, state_q;

    logic          in_bank;
    logic          accept;
    logic [IW-1:0] free_idx, fwd_idx, viol_idx;
    logic          free_any, fwd_found, viol_found;
    logic [N-1:0]  fwd_cand, viol_cand, kill_vec;

    if (BANK_BITS == 0) begin : g_single
        assign in_bank = 1'b1;
    end else begin : g_banked
        assign in_bank = (req_addr[BANK_BITS-1:0] == BANK_BITS'(BANK_ID));
    end

    assign accept = req_valid && in_bank && !flush_valid;

    lsq_free_enc #(.N(N)) u_free (
        .free_vec (~state_q.vld),
        .free_idx (free_idx),
        .free_any (free_any)
    );

    lsq_cam #(.N(N), .AGE_W(AGE_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_cam (
        .ent_vld   (state_q.vld),
        .ent_st    (state_q.st),
        .ent_age   (state_q.age),
        .ent_addr  (state_q.addr),
        .ent_mask  (state_q.mask),
        .q_st      (req_is_store),
        .q_age     (req_age),
        .q_addr    (req_addr),
        .q_mask    (req_mask),
        .fl_age    (flush_age),
        .fwd_cand  (fwd_cand),
        .viol_cand (viol_cand),
        .kill_vec  (kill_vec)
    );

    lsq_age_pick #(.N(N), .AGE_W(AGE_W), .YOUNGEST(1'b1)) u_pick_fwd (
        .cand     (fwd_cand),
        .ages     (state_q.age),
        .pick_idx (fwd_idx),
        .found    (fwd_found)
    );

    lsq_age_pick #(.N(N), .AGE_W(AGE_W), .YOUNGEST(1'b0)) u_pick_viol (
        .cand     (viol_cand),
        .ages     (state_q.age),
        .pick_idx (viol_idx),
        .found    (viol_found)
    );

    always_comb begin
        state_d = state_q;

        state_d.rsp_vld  = accept;
        state_d.rsp_ovf  = accept && !free_any;
        state_d.rsp_hit  = accept && free_any && fwd_found;
        state_d.rsp_data = (accept && free_any && fwd_found) ? state_q.data[fwd_idx] : '0;
        state_d.rsp_viol = accept && free_any && viol_found;
        state_d.rsp_vage = (accept && free_any && viol_found) ? state_q.age[viol_idx] : '0;

        for (int i = 0; i < N; i++) begin
            if (commit_valid && state_q.vld[i] && (state_q.age[i] == commit_age)) begin
                state_d.vld[i] = 1'b0;
            end
        end

        if (flush_valid) begin
            state_d.vld = state_d.vld & ~kill_vec;
        end

        if (accept && free_any) begin
            state_d.vld[free_idx]  = 1'b1;
            state_d.st[free_idx]   = (req_is_store == OP_STORE);
            state_d.age[free_idx]  = req_age;
            state_d.addr[free_idx] = req_addr;
            state_d.mask[free_idx] = req_mask;
            state_d.data[free_idx] = req_is_store ? req_data : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid    = state_q.rsp_vld;
    assign rsp_overflow = state_q.rsp_ovf;
    assign rsp_fwd_hit  = state_q.rsp_hit;
    assign rsp_fwd_data = state_q.rsp_data;
    assign rsp_viol     = state_q.rsp_viol;
    assign rsp_viol_age = state_q.rsp_vage;
    assign bank_full    = &state_q.vld;
endmodule

// File: rtl/lsq_bank_chk.sv
module lsq_bank_chk #(
    parameter int ADDR_W    = 32,
    parameter int BANK_BITS = 0,
    parameter int BANK_ID   = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_is_store,
    input logic [ADDR_W-1:0] req_addr,
    input logic              flush_valid,
    input logic              rsp_valid,
    input logic              rsp_overflow,
    input logic              rsp_fwd_hit,
    input logic              rsp_viol,
    input logic              bank_full
);
    logic mine;
    if (BANK_BITS == 0) begin : g_one
        assign mine = 1'b1;
    end else begin : g_many
        assign mine = (req_addr[BANK_BITS-1:0] == BANK_BITS'(BANK_ID));
    end

    AST_RSP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R1
    AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mine) |=> !rsp_valid); // R2
    AST_HIT_IS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fwd_hit |-> (rsp_valid && !$past(req_is_store))); // R3
    AST_VIOL_IS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> (rsp_valid && $past(req_is_store))); // R5
    AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overflow |-> (rsp_valid && !rsp_fwd_hit && !rsp_viol)); // R7
    AST_FULL_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mine && !flush_valid && bank_full) |=> rsp_overflow); // R7
    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !rsp_valid); // R9
endmodule

bind lsq_bank lsq_bank_chk #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .BANK_ID(BANK_ID)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_addr     (req_addr),
    .flush_valid  (flush_valid),
    .rsp_valid    (rsp_valid),
    .rsp_overflow (rsp_overflow),
    .rsp_fwd_hit  (rsp_fwd_hit),
    .rsp_viol     (rsp_viol),
    .bank_full    (bank_full)
);

// File: tb/lsq_bank_tb.sv
module lsq_bank_tb;
    localparam int N = 8, AW = 8, ADW = 16, DW = 32, MW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_is_store = 0, commit_valid = 0, flush_valid = 0;
    logic [AW-1:0]  req_age = '0, commit_age = '0, flush_age = '0;
    logic [ADW-1:0] req_addr = '0;
    logic [MW-1:0]  req_mask = '0;
    logic [DW-1:0]  req_data = '0;
    logic rsp_valid, rsp_overflow, rsp_fwd_hit, rsp_viol, bank_full;
    logic [DW-1:0] rsp_fwd_data;
    logic [AW-1:0] rsp_viol_age;

    int total = 0, bad = 0;
    bit finished = 0;

    logic           m_vld [N];
    logic           m_st  [N];
    logic [AW-1:0]  m_age [N];
    logic [ADW-1:0] m_addr[N];
    logic [MW-1:0]  m_mask[N];
    logic [DW-1:0]  m_data[N];

    always #10 clk = ~clk;

    lsq_bank #(.N(N), .AGE_W(AW), .ADDR_W(ADW), .DATA_W(DW), .MASK_W(MW),
               .BANK_BITS(2), .BANK_ID(1)) u_dut (.*);

    function automatic logic m_older(input logic [AW-1:0] a, input logic [AW-1:0] b);
        logic [AW-1:0] d;
        d = a - b;
        return d[AW-1];
    endfunction

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (m_vld[i]) c++;
        return c;
    endfunction

    function automatic logic m_has_age(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_age[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic st, input logic [AW-1:0] age, input logic [ADW-1:0] addr,
                         input logic [MW-1:0] mask, input logic [DW-1:0] data);
        logic inb, ovf, hit, viol, hf, vf;
        logic [DW-1:0] fdat;
        logic [AW-1:0] vage, best_f, best_v;
        int slot;
        inb = (addr[1:0] == 2'd1);
        ovf = inb && (m_count() == N);
        hf = 0; vf = 0; best_f = '0; best_v = '0; fdat = '0; slot = -1;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_addr[i] == addr && (m_mask[i] & mask) != 0) begin
                if (!st && m_st[i] && m_older(m_age[i], age) && (!hf || m_older(best_f, m_age[i]))) begin
                    hf = 1; best_f = m_age[i]; fdat = m_data[i];
                end
                if (st && !m_st[i] && m_older(age, m_age[i]) && (!vf || m_older(m_age[i], best_v))) begin
                    vf = 1; best_v = m_age[i];
                end
            end
            if (!m_vld[i] && slot < 0) slot = i;
        end
        hit = inb && !ovf && hf;
        viol = inb && !ovf && vf;
        vage = viol ? best_v : '0;
        if (!hit) fdat = '0;
        if (inb && !ovf) begin
            m_vld[slot] = 1; m_st[slot] = st; m_age[slot] = age;
            m_addr[slot] = addr; m_mask[slot] = mask; m_data[slot] = st ? data : '0;
        end
        req_valid = 1; req_is_store = st; req_age = age; req_addr = addr;
        req_mask = mask; req_data = data;
        @(negedge clk);
        req_valid = 0;
        check(inb ? "R1 rsp_valid" : "R2 rsp_valid", {63'd0, rsp_valid}, {63'd0, inb});
        if (inb) begin
            check("R7 overflow", {63'd0, rsp_overflow}, {63'd0, ovf});
            check(st ? "R5 viol" : "R3 fwd_hit", st ? {63'd0, rsp_viol} : {63'd0, rsp_fwd_hit},
                  st ? {63'd0, viol} : {63'd0, hit});
            if (st) check("R5 viol_age", {56'd0, rsp_viol_age}, {56'd0, vage});
            else    check("R4 fwd_data", {32'd0, rsp_fwd_data}, {32'd0, fdat});
        end
    endtask

    task automatic commit(input logic [AW-1:0] age);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_age[i] == age) m_vld[i] = 0;
        commit_valid = 1; commit_age = age;
        @(negedge clk);
        commit_valid = 0;
        check("R8 full after commit", {63'd0, bank_full}, {63'd0, m_count() == N});
    endtask

    task automatic flush(input logic [AW-1:0] age, input logic with_req);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_older(age, m_age[i])) m_vld[i] = 0;
        flush_valid = 1; flush_age = age;
        req_valid = with_req; req_addr = 16'h0005; req_age = age + 8'd1; req_mask = 4'hf;
        @(negedge clk);
        flush_valid = 0; req_valid = 0;
        check("R9 no rsp on flush", {63'd0, rsp_valid}, 64'd0);
        check("R9 full after flush", {63'd0, bank_full}, {63'd0, m_count() == N});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'd7331));
        for (int i = 0; i < N; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        check("R10 rsp_valid reset", {63'd0, rsp_valid}, 64'd0);
        check("R10 full reset", {63'd0, bank_full}, 64'd0);
        check("R10 data reset", {32'd0, rsp_fwd_data}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        issue(1, 8'd10, 16'h0005, 4'hf, 32'h1111);      // R1
        issue(1, 8'd12, 16'h0005, 4'h3, 32'h2222);
        issue(0, 8'd15, 16'h0005, 4'h1, 0);             // R3 -> 2222
        issue(0, 8'd11, 16'h0005, 4'hf, 0);             // R3 -> 1111
        issue(0, 8'd5,  16'h0005, 4'hf, 0);             // R4 miss
        issue(0, 8'd20, 16'h0005, 4'h8, 0);             // R4 disjoint mask skip
        issue(0, 8'd21, 16'h0009, 4'hf, 0);             // R4 other word
        issue(1, 8'd9,  16'h0005, 4'hf, 32'h9999);      // R5 viol age 11
        check("R7 bank_full", {63'd0, bank_full}, 64'd1);
        issue(0, 8'd30, 16'h0005, 4'hf, 0);             // R7 overflow
        issue(1, 8'd31, 16'h0006, 4'hf, 32'h7);         // R2 other bank
        commit(8'd12);                                   // R8
        issue(0, 8'd32, 16'h0005, 4'h1, 0);             // R8 forwards 1111
        flush(8'd11, 1'b1);                              // R9
        issue(1, 8'd13, 16'h0005, 4'hf, 32'h13);        // R9 no viol
        flush(8'd4, 1'b0);
        issue(1, 8'd250, 16'h0005, 4'hf, 32'h3333);     // R6 wrap
        issue(0, 8'd3,   16'h0005, 4'hf, 0);
        issue(1, 8'd2,   16'h0005, 4'hf, 32'h4444);
        issue(0, 8'd248, 16'h0005, 4'hf, 0);
        flush(8'd200, 1'b0);

        base = 8'd100;
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < 16; k++) begin
                if ($urandom % 10 == 0 && m_count() > 0) begin
                    int s;
                    s = $urandom % N;
                    while (!m_vld[s]) s = (s + 1) % N;
                    commit(m_age[s]);
                end else begin
                    logic [AW-1:0] a;
                    logic [ADW-1:0] ad;
                    a = base + AW'($urandom % 32);
                    if (!m_has_age(a)) begin
                        ad = {12'd0, 2'($urandom % 3), ($urandom % 8 == 0) ? 2'd2 : 2'd1};
                        issue(1'($urandom), a, ad, 4'($urandom % 15 + 1), $urandom);
                    end
                end
            end
            flush(base - 8'd1, 1'b0);
            base = base + 8'd16;
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule